// File: doc/BRIEF.md
# Edge-Capturing General-Purpose I/O Port

This block is a register-mapped general-purpose I/O port with up to 32 pins. Software sets up each pin through a simple valid/write strobe bus. It can enable a pin, choose whether the pin drives or senses, set the driven values and read back the pin states. On the pad side the block takes an input vector and returns an output vector with a matching output-enable vector.

Each sensed pin can arm a rising-edge trigger, a falling-edge trigger or both. Arming both captures every transition. Pad inputs pass through a synchroniser, and an edge is found by comparing the synchronised value with its value one clock earlier. A detected edge on an armed pin sets a sticky status bit. Software clears that bit by writing a one to it. A single level interrupt is high while any status bit is set. There is no level-triggered capture mode.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset every register reads zero, `pad_oe` is zero, `pad_out` is zero and `irq` is low.
- R2: A bus access hits a register only when `bus_addr` is word-aligned and names one of these: 0x00 enable, 0x04 direction (1 = sense, 0 = drive), 0x08 level, 0x0C rising arm, 0x10 falling arm, 0x14 status. Read data appears on `bus_rdata` in the cycle after the read strobe. Bits at or above `NUM_PINS` always read zero. Unmapped or misaligned reads return zero, and writes to them change nothing.
- R3: `pad_oe[i]` is 1 exactly when pin i is enabled with direction 0. `pad_out[i]` equals the level register bit when `pad_oe[i]` is 1 and is 0 otherwise.
- R4: When pin i is enabled as an input and its rising arm is set, a 0-to-1 change on `pad_in[i]` sets status bit i at the third rising clock edge after the change. It is still clear after the second.
- R5: A falling arm captures 1-to-0 changes in the same way. A pin with only one arm ignores the other direction. A pin with both arms captures both.
- R6: Capture is edge-only. A pin held at a steady level does not set its status bit again after that bit is cleared.
- R7: A write to the status register clears exactly the bits written as 1 and leaves all other bits unchanged. Writes to status never set a bit.
- R8: When a clear of a status bit and a new capture for that bit fall in the same cycle, the bit stays set.
- R9: `irq` is high exactly while at least one status bit is set.
- R10: No capture happens on a pin that is disabled, on a pin set to drive, or on a pin with both arms clear.
- R11: A read of the level register returns the synchronised pad value for enabled input pins. It returns the level register bit for enabled output pins and zero for disabled pins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| pad_in | input | NUM_PINS | Pad input values |
| pad_out | output | NUM_PINS | Pad output values |
| pad_oe | output | NUM_PINS | Pad output enables |
| irq | output | 1 | Level interrupt, OR of the status bits |

## Verification
A register write takes effect at the clock edge that samples the strobe, so `pad_oe` and `pad_out` are checked at the following falling edge. Read data is registered, so each read samples `bus_rdata` at the falling edge after the strobe's rising edge. A pad change made at a falling edge reaches the status register and `irq` at the third rising edge. The bench checks `irq` low after the first and second rising edges and high after the third. To test a clear and a capture in the same cycle, the bench places the clear strobe on exactly that third edge. All stimulus changes at falling edges, and all sampling happens there too.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

    localparam int MAX_PINS = 32;

    typedef logic [MAX_PINS-1:0] pinword_t;

    // word index = byte address / 4; order fixed by the register map
    typedef enum logic [2:0] {
        IDX_ENABLE = 3'd0,
        IDX_DIR    = 3'd1,
        IDX_LEVEL  = 3'd2,
        IDX_RISE   = 3'd3,
        IDX_FALL   = 3'd4,
        IDX_STATUS = 3'd5
    } reg_idx_e;

    localparam int NUM_REGS = 6;

    typedef struct packed {
        pinword_t en;
        pinword_t dir;
        pinword_t lvl;
        pinword_t rise;
        pinword_t fall;
        pinword_t status;
        pinword_t rdata;
    } ctrl_state_t;

    function automatic pinword_t pin_mask(int n);
        pinword_t m;
        m = '0;
        for (int i = 0; i < MAX_PINS; i++) begin
            if (i < n) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/gpio_sync_chain.sv
module gpio_sync_chain #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] st_d [STAGES];
    logic [W-1:0] st_q [STAGES];

    always_comb begin
        st_d[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            st_d[s] = st_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                st_q[s] <= '0;
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q[STAGES-1];

endmodule

// File: rtl/gpio_edge_sense.sv
module gpio_edge_sense #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cur,
    input  logic [W-1:0] arm_rise,
    input  logic [W-1:0] arm_fall,
    output logic [W-1:0] rise_hit,
    output logic [W-1:0] fall_hit,
    output logic [W-1:0] evt
);

    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = cur;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    for (genvar i = 0; i < W; i++) begin : g_pin
        assign rise_hit[i] = arm_rise[i] &  cur[i] & ~prev_q[i];
        assign fall_hit[i] = arm_fall[i] & ~cur[i] &  prev_q[i];
        assign evt[i]      = rise_hit[i] | fall_hit[i];
    end

    // R4: a rising hit only where the sampled value went 0 -> 1
    p_rise_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_hit & ~(cur & ~$past(cur))) == '0);

    // R5: a falling hit only where the sampled value went 1 -> 0
    p_fall_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_hit & ~(~cur & $past(cur))) == '0);

    // R6: no event on a pin whose value did not change
    p_edge_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (evt & ~(cur ^ $past(cur))) == '0);

endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
    import gpio_edge_pkg::*;
#(
    parameter int NUM_PINS    = 8,
    parameter int ADDR_W      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic                irq
);

    localparam pinword_t   MASK     = pin_mask(NUM_PINS);
    localparam int         IDX_W    = ADDR_W - 2;

    ctrl_state_t state_d, state_q;

    logic [NUM_PINS-1:0] sync_vec;
    logic [NUM_PINS-1:0] arm_rise, arm_fall;
    logic [NUM_PINS-1:0] rise_hit, fall_hit, evt_vec;
    pinword_t            evt_w, clr_vec, stat_q, level_view;
    logic                hit_ok;
    logic [IDX_W-1:0]    word_idx;

    gpio_sync_chain #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pad_in),
        .dout (sync_vec)
    );

    // sensing needs enable=1 and direction=1 (input)
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_arm
        assign arm_rise[i] = state_q.en[i] & state_q.dir[i] & state_q.rise[i];
        assign arm_fall[i] = state_q.en[i] & state_q.dir[i] & state_q.fall[i];
        assign pad_oe[i]   = state_q.en[i] & ~state_q.dir[i];
        assign pad_out[i]  = pad_oe[i] & state_q.lvl[i];
    end

    gpio_edge_sense #(.W(NUM_PINS)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .cur     (sync_vec),
        .arm_rise(arm_rise),
        .arm_fall(arm_fall),
        .rise_hit(rise_hit),
        .fall_hit(fall_hit),
        .evt     (evt_vec)
    );

    always_comb begin
        evt_w = '0;
        evt_w[NUM_PINS-1:0] = evt_vec;
    end

    always_comb begin
        pinword_t sync_w;
        sync_w = '0;
        sync_w[NUM_PINS-1:0] = sync_vec;
        level_view = (state_q.en & state_q.dir & sync_w)
                   | (state_q.en & ~state_q.dir & state_q.lvl);
    end

    assign word_idx = bus_addr[ADDR_W-1:2];
    assign hit_ok   = (bus_addr[1:0] == 2'b00) && (int'(word_idx) < NUM_REGS);

    always_comb begin
        pinword_t rd_mux;
        state_d = state_q;
        clr_vec = '0;
        rd_mux  = '0;

        if (hit_ok) begin
            case (reg_idx_e'(word_idx[2:0]))
                IDX_ENABLE: rd_mux = state_q.en;
                IDX_DIR:    rd_mux = state_q.dir;
                IDX_LEVEL:  rd_mux = level_view;
                IDX_RISE:   rd_mux = state_q.rise;
                IDX_FALL:   rd_mux = state_q.fall;
                IDX_STATUS: rd_mux = state_q.status;
                default:    rd_mux = '0;
            endcase
        end

        if (bus_sel && bus_wr && hit_ok) begin
            case (reg_idx_e'(word_idx[2:0]))
                IDX_ENABLE: state_d.en   = bus_wdata & MASK;
                IDX_DIR:    state_d.dir  = bus_wdata & MASK;
                IDX_LEVEL:  state_d.lvl  = bus_wdata & MASK;
                IDX_RISE:   state_d.rise = bus_wdata & MASK;
                IDX_FALL:   state_d.fall = bus_wdata & MASK;
                IDX_STATUS: clr_vec      = bus_wdata & MASK;
                default:    clr_vec      = '0;
            endcase
        end

        // a capture in the same cycle as its clear wins
        state_d.status = (state_q.status & ~clr_vec) | evt_w;

        if (bus_sel && !bus_wr) begin
            state_d.rdata = rd_mux & MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign stat_q    = state_q.status;
    assign bus_rdata = state_q.rdata;
    assign irq       = |state_q.status;

    // R7: a set status bit stays set unless a clear named it
    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(stat_q) & ~$past(clr_vec)) & ~stat_q) == '0);

    // R8: every event lands in status on the next edge, clear or not
    p_capture_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(evt_w) & ~stat_q) == '0);

    // R9: the interrupt can only rise after an event was captured
    p_irq_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(evt_w) != '0));

    // R3: a driven pad never coincides with a sensed pin
    p_oe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & (arm_rise | arm_fall)) == '0);

endmodule

// File: tb/gpio_edge_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_edge_ctrl_bench;

    localparam int NP = 8;
    localparam logic [4:0] A_EN = 5'h00, A_DIR = 5'h04, A_LVL = 5'h08,
                           A_RISE = 5'h0C, A_FALL = 5'h10, A_STAT = 5'h14;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0, bus_wr = 1'b0;
    logic [4:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_out, pad_oe;
    logic          irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    gpio_edge_ctrl #(.NUM_PINS(NP), .ADDR_W(5), .SYNC_STAGES(2)) u_gpio_edge_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic rd_chk(string req, logic [4:0] a, logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(req, d, exp);
    endtask

    task automatic set_pad(logic [NP-1:0] v, int settle);
        @(negedge clk);
        pad_in = v;
        repeat (settle) @(posedge clk);
    endtask

    task automatic t_reset;
        chk("R1 pad_oe", 32'(pad_oe), 32'h0);
        chk("R1 pad_out", 32'(pad_out), 32'h0);
        chk("R1 irq", 32'(irq), 32'h0);
        rd_chk("R1 enable", A_EN, 0);
        rd_chk("R1 dir", A_DIR, 0);
        rd_chk("R1 level", A_LVL, 0);
        rd_chk("R1 rise", A_RISE, 0);
        rd_chk("R1 fall", A_FALL, 0);
        rd_chk("R1 status", A_STAT, 0);
    endtask

    task automatic t_regmap;
        wr(A_EN, 32'hFFFF_FFFF);
        rd_chk("R2 enable masked", A_EN, 32'h0000_00FF);
        wr(A_DIR, 32'h0000_01A5);
        rd_chk("R2 dir", A_DIR, 32'h0000_00A5);
        wr(A_RISE, 32'h0000_003C);
        rd_chk("R2 rise", A_RISE, 32'h0000_003C);
        wr(A_FALL, 32'h0000_00C3);
        rd_chk("R2 fall", A_FALL, 32'h0000_00C3);
        rd_chk("R2 unmapped read", 5'h18, 0);
        wr(5'h05, 32'h0);
        rd_chk("R2 misaligned write ignored", A_EN, 32'h0000_00FF);
        rd_chk("R2 misaligned read", 5'h01, 0);
        wr(A_STAT, 32'hFF);
        rd_chk("R7 status write never sets", A_STAT, 0);
        wr(A_EN, 0); wr(A_DIR, 0); wr(A_RISE, 0); wr(A_FALL, 0);
    endtask

    task automatic t_drive;
        set_pad(8'h01, 4);
        wr(A_EN, 32'h0F);
        wr(A_DIR, 32'h03);
        wr(A_LVL, 32'hFF);
        chk("R3 pad_oe", 32'(pad_oe), 32'h0C);
        chk("R3 pad_out", 32'(pad_out), 32'h0C);
        rd_chk("R11 level view", A_LVL, 32'h0D);
        wr(A_LVL, 32'h04);
        chk("R3 pad_out after level write", 32'(pad_out), 32'h04);
    endtask

    task automatic t_edges;
        set_pad(8'h00, 5);
        wr(A_EN, 32'hFF);
        wr(A_DIR, 32'hFF);
        wr(A_RISE, 32'h01);
        wr(A_FALL, 32'h02);
        wr(A_STAT, 32'hFF);
        // R4 latency: change at a falling edge, status at third rising edge
        @(negedge clk);
        pad_in = 8'h01;
        @(posedge clk); @(negedge clk);
        chk("R4 irq after 1 edge", 32'(irq), 0);
        @(posedge clk); @(negedge clk);
        chk("R4 irq after 2 edges", 32'(irq), 0);
        @(posedge clk); @(negedge clk);
        chk("R4 irq after 3 edges", 32'(irq), 1);
        rd_chk("R4 rising capture", A_STAT, 32'h01);
        set_pad(8'h03, 5);
        rd_chk("R5 rise ignored on fall-only pin", A_STAT, 32'h01);
        wr(A_STAT, 32'h01);
        rd_chk("R7 clear", A_STAT, 0);
        chk("R9 irq low when clear", 32'(irq), 0);
        repeat (10) @(posedge clk);
        rd_chk("R6 steady high no recapture", A_STAT, 0);
        set_pad(8'h01, 5);
        rd_chk("R5 falling capture", A_STAT, 32'h02);
        chk("R9 irq high", 32'(irq), 1);
        wr(A_RISE, 32'h05);
        wr(A_FALL, 32'h06);
        set_pad(8'h05, 5);
        rd_chk("R5 both arms rising", A_STAT, 32'h06);
        wr(A_STAT, 32'h04);
        rd_chk("R7 clears only ones", A_STAT, 32'h02);
        set_pad(8'h01, 5);
        rd_chk("R5 both arms falling", A_STAT, 32'h06);
        wr(A_STAT, 32'hFF);
        rd_chk("R7 clear all", A_STAT, 0);
    endtask

    task automatic t_race;
        set_pad(8'h05, 5);
        rd_chk("R8 setup", A_STAT, 32'h04);
        @(negedge clk);
        pad_in = 8'h01;
        @(posedge clk);
        @(posedge clk);
        wr(A_STAT, 32'h04); // strobe sampled on the capture edge
        rd_chk("R8 capture survives clear", A_STAT, 32'h04);
        wr(A_STAT, 32'h04);
        rd_chk("R8 later clear works", A_STAT, 0);
    endtask

    task automatic t_disable;
        wr(A_EN, 32'hF7);
        wr(A_DIR, 32'hEF);
        wr(A_RISE, 32'h18);
        wr(A_FALL, 32'h18);
        wr(A_STAT, 32'hFF);
        set_pad(8'h39, 5);
        rd_chk("R10 no capture on gated pins", A_STAT, 0);
        chk("R10 irq stays low", 32'(irq), 0);
        set_pad(8'h01, 5);
        rd_chk("R10 no capture on falling", A_STAT, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_regmap;
        t_drive;
        t_edges;
        t_race;
        t_disable;
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule